// File: doc/BRIEF.md
# Bus Address/Data Breakpoint Unit

This block watches every bus cycle of a small 16-bit processor and raises a break when a cycle matches a programmed target. Each cycle carries an access kind (instruction fetch, data read, data write or idle), a size (byte or word), an address and the bus data. The block compares the address with a programmed break address. It also qualifies the cycle by access kind and size. When told to, it compares the data lanes with a programmed 16-bit break value.

Data comparison follows the bus's lane rules. A byte access always travels on the upper eight data lines, whatever the address parity, so it is compared with the high byte of the break value. A word access at an even address uses both lanes. A word access at an odd address uses only the upper lane.

A match sets a sticky status flag. If the enable bit is set, the match also drives an interrupt line. That line is a separate output and has no path through the processor's global interrupt mask. Software programs the block through a word-wide register port with one byte enable per lane.

Top module: `bkpt_unit`

## Requirements
- R1: After reset the control word, the status word (flag bit 0, enable bit 1) and the break address read as 0, and `brk_irq` is 0.
- R2: Registers sit at port offsets 0x00 control (low byte only), 0x02 status, 0x04 break address and 0x06 break data. Each `reg_be` bit gates its own byte lane. `reg_rdata` shows the register selected by `reg_addr` one clock edge later. Unmapped offsets read as 0.
- R3: Control bits 7:6 select the access kind: 00 read or write, 01 read, 10 fetch, 11 write. `bus_kind` codes are 0 fetch, 1 read, 2 write and 3 idle. An idle cycle never matches, and an address that differs from the break address never matches.
- R4: A control value of 0x80 with break address 0x025A breaks on the fetch from 0x025A only. It does not break on the fetch from 0x0258, and it does not break on a data read of 0x025A.
- R5: Control bits 5:4 qualify the size: 01 byte only, 10 word only, 00 or 11 either size.
- R6: With control bit 3 set, a byte access (`bus_word`=0) matches only when data bits 15:8 equal break-data bits 15:8, at even and odd addresses alike. With bit 3 clear, data has no effect.
- R7: With control bit 3 set, a word access at an even address compares all 16 bits. A word access at an odd address compares bits 15:8 only.
- R8: A matching strobe sampled on clock edge k sets the flag and the interrupt on edge k+1, never earlier.
- R9: `brk_irq` is registered. It is high exactly when the flag is set and the enable bit was set before the edge.
- R10: Writing status with `reg_be[0]`=1 and bit 0 = 0 clears the flag. Writing bit 0 = 1, or writing with `reg_be[0]`=0, leaves the flag as it was. Software can never set the flag.
- R11: A match that reaches the flag on the same edge as a clear write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_be | input | 2 | Byte enables (bit 1 high lane, bit 0 low lane) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| bus_strobe | input | 1 | Bus cycle valid |
| bus_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 idle |
| bus_word | input | 1 | 1 word access, 0 byte access |
| bus_addr | input | 16 | Bus cycle address |
| bus_data | input | 16 | Bus cycle data |
| brk_irq | output | 1 | Break interrupt request, independent of the CPU mask |

## Verification
The assertions check on every cycle that a compare hit only follows a strobe, that the flag rises only after a hit, that the flag holds unless it is cleared, and that a hit overrides a simultaneous clear. They also check that the interrupt never rises without the flag or with the enable bit clear. Only the bench scenarios can show that the right cycles match: the kind and size qualifiers, the byte-lane choice for byte, even-word and odd-word accesses, and the register decoding. The bench sweeps every control combination against every bus kind, size, address parity and data disturbance to show these.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // bus_kind codes
  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;
  localparam logic [1:0] KIND_IDLE  = 2'd3;

  // control bits 7:6
  typedef enum logic [1:0] {
    SEL_RD_OR_WR = 2'b00,
    SEL_READ     = 2'b01,
    SEL_FETCH    = 2'b10,
    SEL_WRITE    = 2'b11
  } sel_e;

  // control bits 5:4
  typedef enum logic [1:0] {
    QUAL_EITHER = 2'b00,
    QUAL_BYTE   = 2'b01,
    QUAL_WORD   = 2'b10,
    QUAL_BOTH   = 2'b11
  } qual_e;

  typedef struct packed {
    sel_e       sel;
    qual_e      qual;
    logic       dce;
    logic [2:0] spare;
  } ctrl_t;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h02;
  localparam logic [7:0] OFS_ADDR = 8'h04;
  localparam logic [7:0] OFS_DATA = 8'h06;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_IEN_BIT  = 1;

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int REG_AW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [DATA_W/8-1:0]   reg_be,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  flag_i,
  output sel_e                  sel_o,
  output qual_e                 qual_o,
  output logic                  dce_o,
  output logic [ADDR_W-1:0]     bar_o,
  output logic [DATA_W-1:0]     bdr_o,
  output logic                  ien_o,
  output logic                  clr_o
);

  localparam int LANES   = DATA_W / 8;
  localparam int A_LANES = ADDR_W / 8;

  ctrl_t ctrl_q;
  logic  wr_ctrl, wr_stat, wr_addr, wr_data;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == REG_AW'(OFS_CTRL));
    wr_stat = reg_wr && (reg_addr == REG_AW'(OFS_STAT));
    wr_addr = reg_wr && (reg_addr == REG_AW'(OFS_ADDR));
    wr_data = reg_wr && (reg_addr == REG_AW'(OFS_DATA));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl && reg_be[0]) begin
      ctrl_q <= ctrl_t'(reg_wdata[7:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_o <= 1'b0;
    end else if (wr_stat && reg_be[0]) begin
      ien_o <= reg_wdata[STAT_IEN_BIT];
    end
  end

  // write-zero-to-clear request for the flag
  assign clr_o = wr_stat && reg_be[0] && !reg_wdata[STAT_FLAG_BIT];

  // break address: resettable, one lane per byte enable
  for (genvar i = 0; i < A_LANES; i++) begin : g_addr_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        bar_o[i*8 +: 8] <= 8'h00;
      end else if (wr_addr && reg_be[i]) begin
        bar_o[i*8 +: 8] <= reg_wdata[i*8 +: 8];
      end
    end
  end

  // break data: no reset value, software must program it
  for (genvar i = 0; i < LANES; i++) begin : g_data_lane
    always_ff @(posedge clk) begin
      if (wr_data && reg_be[i]) begin
        bdr_o[i*8 +: 8] <= reg_wdata[i*8 +: 8];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      REG_AW'(OFS_CTRL): rd_next[7:0] = ctrl_q;
      REG_AW'(OFS_STAT): begin
        rd_next[STAT_FLAG_BIT] = flag_i;
        rd_next[STAT_IEN_BIT]  = ien_o;
      end
      REG_AW'(OFS_ADDR): rd_next[ADDR_W-1:0] = bar_o;
      REG_AW'(OFS_DATA): rd_next = bdr_o;
      default:           rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_next;
    end
  end

  assign sel_o  = ctrl_q.sel;
  assign qual_o = ctrl_q.qual;
  assign dce_o  = ctrl_q.dce;

  assert_clear_only_on_write_R10 : assert property (@(posedge clk) disable iff (rst)
    clr_o |-> (reg_wr && reg_be[0]));

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic [1:0]        kind_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  sel_e              sel_i,
  input  qual_e             qual_i,
  input  logic              dce_i,
  input  logic [ADDR_W-1:0] bar_i,
  input  logic [DATA_W-1:0] bdr_i,
  output logic              hit_q
);

  localparam int LANES = DATA_W / 8;
  localparam int TOP   = LANES - 1;

  logic [LANES-1:0] lane_eq;
  logic [LANES-1:0] lane_use;
  logic kind_ok, size_ok, addr_ok, data_ok;

  // Byte accesses and odd word accesses ride on the top lane only;
  // an even word access brings every lane into the compare.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_eq[i] = (data_i[i*8 +: 8] == bdr_i[i*8 +: 8]);
    if (i == TOP) begin : g_top
      assign lane_use[i] = 1'b1;
    end else begin : g_low
      assign lane_use[i] = word_i && !addr_i[0];
    end
  end

  always_comb begin
    case (sel_i)
      SEL_FETCH:    kind_ok = (kind_i == KIND_FETCH);
      SEL_READ:     kind_ok = (kind_i == KIND_READ);
      SEL_WRITE:    kind_ok = (kind_i == KIND_WRITE);
      default:      kind_ok = (kind_i == KIND_READ) || (kind_i == KIND_WRITE);
    endcase
    case (qual_i)
      QUAL_BYTE:    size_ok = !word_i;
      QUAL_WORD:    size_ok = word_i;
      default:      size_ok = 1'b1;
    endcase
    addr_ok = (addr_i == bar_i);
    data_ok = !dce_i || (&(lane_eq | ~lane_use));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= strobe_i && kind_ok && size_ok && addr_ok && data_ok;
    end
  end

  assert_hit_after_strobe_R8 : assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(strobe_i));

  assert_idle_never_hits_R3 : assert property (@(posedge clk) disable iff (rst)
    hit_q |-> ($past(kind_i) != KIND_IDLE));

endmodule

// File: rtl/bkpt_flag.sv
module bkpt_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_d;

  // a hit outranks a software clear on the same edge
  assign flag_d = hit_i || (flag_o && !clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      irq_o  <= flag_d && ien_i;
    end
  end

  assert_flag_rise_from_hit_R8 : assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(hit_i));

  assert_flag_sticky_R10 : assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);

  assert_hit_beats_clear_R11 : assert property (@(posedge clk) disable iff (rst)
    (hit_i && clr_i) |=> flag_o);

  assert_irq_needs_flag_R9 : assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);

  assert_irq_needs_enable_R9 : assert property (@(posedge clk) disable iff (rst)
    !ien_i |=> !irq_o);

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int REG_AW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W/8-1:0] reg_be,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                bus_strobe,
  input  logic [1:0]          bus_kind,
  input  logic                bus_word,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_data,
  output logic                brk_irq
);

  sel_e              sel;
  qual_e             qual;
  logic              dce, ien, clr, hit, flag;
  logic [ADDR_W-1:0] bar;
  logic [DATA_W-1:0] bdr;

  bkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flag_i(flag),
    .sel_o(sel), .qual_o(qual), .dce_o(dce),
    .bar_o(bar), .bdr_o(bdr), .ien_o(ien), .clr_o(clr)
  );

  bkpt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst),
    .strobe_i(bus_strobe), .kind_i(bus_kind), .word_i(bus_word),
    .addr_i(bus_addr), .data_i(bus_data),
    .sel_i(sel), .qual_i(qual), .dce_i(dce),
    .bar_i(bar), .bdr_i(bdr),
    .hit_q(hit)
  );

  bkpt_flag u_flag (
    .clk(clk), .rst(rst),
    .hit_i(hit), .clr_i(clr), .ien_i(ien),
    .flag_o(flag), .irq_o(brk_irq)
  );

endmodule

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [1:0]  reg_be = 2'b00;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        bus_strobe = 1'b0;
  logic [1:0]  bus_kind = 2'd3;
  logic        bus_word = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [15:0] bus_data = 16'h0;
  logic        brk_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bkpt_unit u0 (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_strobe(bus_strobe), .bus_kind(bus_kind), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .brk_irq(brk_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  // drive one bus cycle, return at the negedge after the flag edge
  task automatic cyc(input int kind, input bit word, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_strobe = 1'b1; bus_kind = 2'(kind); bus_word = word; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_strobe = 1'b0; bus_kind = 2'd3;
    @(negedge clk);
  endtask

  function automatic bit exp_hit(int sel, int qual, int dce, int kind, bit word,
                                 logic [15:0] a, logic [15:0] d,
                                 logic [15:0] bar, logic [15:0] bdr);
    bit k_ok, s_ok, d_ok;
    case (sel)
      0: k_ok = (kind == 1) || (kind == 2);
      1: k_ok = (kind == 1);
      2: k_ok = (kind == 0);
      default: k_ok = (kind == 2);
    endcase
    s_ok = (qual == 1) ? !word : (qual == 2) ? word : 1'b1;
    d_ok = (dce == 0) || ((d[15:8] == bdr[15:8]) && (!(word && !a[0]) || (d[7:0] == bdr[7:0])));
    return k_ok && s_ok && d_ok && (a == bar);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] bdr_val;
    bdr_val = 16'hA55A;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {15'd0, brk_irq}, 16'h0);
    rd(8'h00, v); chk("R1 ctrl", v, 16'h0000);
    rd(8'h02, v); chk("R1 status", v, 16'h0000);
    rd(8'h04, v); chk("R1 addr", v, 16'h0000);

    // R2 register port
    wr(8'h06, 2'b11, bdr_val);
    rd(8'h06, v); chk("R2 data", v, bdr_val);
    wr(8'h04, 2'b11, 16'h1234);
    rd(8'h04, v); chk("R2 addr full", v, 16'h1234);
    wr(8'h04, 2'b10, 16'hAB00);
    rd(8'h04, v); chk("R2 addr high lane", v, 16'hAB34);
    wr(8'h04, 2'b01, 16'hFFCD);
    rd(8'h04, v); chk("R2 addr low lane", v, 16'hABCD);
    wr(8'h00, 2'b01, 16'h0038);
    wr(8'h00, 2'b10, 16'hFFFF);
    rd(8'h00, v); chk("R2 ctrl high lane ignored", v, 16'h0038);
    rd(8'h08, v); chk("R2 unmapped", v, 16'h0000);

    // R4 fetch break example
    wr(8'h00, 2'b01, 16'h0080);
    wr(8'h04, 2'b11, 16'h025A);
    wr(8'h02, 2'b01, 16'h0002);
    cyc(0, 1'b1, 16'h0258, 16'h0000);
    chk("R4 fetch 0258", {15'd0, brk_irq}, 16'h0);
    cyc(1, 1'b1, 16'h025A, 16'h0000);
    chk("R4 read 025A", {15'd0, brk_irq}, 16'h0);
    rd(8'h02, v); chk("R4 status after read", v, 16'h0002);

    // R8 timing of a fetch hit
    @(negedge clk);
    bus_strobe = 1'b1; bus_kind = 2'd0; bus_word = 1'b1; bus_addr = 16'h025A;
    @(negedge clk);
    bus_strobe = 1'b0; bus_kind = 2'd3;
    chk("R8 irq not early", {15'd0, brk_irq}, 16'h0);
    @(negedge clk);
    chk("R4 R8 fetch 025A irq", {15'd0, brk_irq}, 16'h1);
    rd(8'h02, v); chk("R8 status", v, 16'h0003);

    // R10 status write semantics
    wr(8'h02, 2'b01, 16'h0003);
    rd(8'h02, v); chk("R10 write one keeps flag", v, 16'h0003);
    wr(8'h02, 2'b10, 16'h0000);
    rd(8'h02, v); chk("R10 high lane no clear", v, 16'h0003);
    wr(8'h02, 2'b01, 16'h0002);
    rd(8'h02, v); chk("R10 clear", v, 16'h0002);
    chk("R10 irq drops", {15'd0, brk_irq}, 16'h0);
    wr(8'h02, 2'b01, 16'h0003);
    rd(8'h02, v); chk("R10 no software set", v, 16'h0002);

    // R11 hit meets clear on the same edge
    @(negedge clk);
    bus_strobe = 1'b1; bus_kind = 2'd0; bus_word = 1'b1; bus_addr = 16'h025A;
    @(negedge clk);
    bus_strobe = 1'b0; bus_kind = 2'd3;
    reg_wr = 1'b1; reg_addr = 8'h02; reg_be = 2'b01; reg_wdata = 16'h0002;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b00;
    rd(8'h02, v); chk("R11 hit beats clear", v, 16'h0003);

    // R9 enable gating
    wr(8'h02, 2'b01, 16'h0000);
    cyc(0, 1'b0, 16'h025A, 16'h0000);
    chk("R9 irq masked by enable", {15'd0, brk_irq}, 16'h0);
    rd(8'h02, v); chk("R9 flag without enable", v, 16'h0001);
    wr(8'h02, 2'b01, 16'h0003);
    chk("R9 irq one edge after enable", {15'd0, brk_irq}, 16'h0);
    @(negedge clk);
    chk("R9 irq after enable", {15'd0, brk_irq}, 16'h1);

    // R3 R5 R6 R7 sweep
    for (int sel = 0; sel < 4; sel++)
      for (int qual = 0; qual < 4; qual++)
        for (int dce = 0; dce < 2; dce++) begin
          wr(8'h00, 2'b01, 16'((sel << 6) | (qual << 4) | (dce << 3)));
          for (int odd = 0; odd < 2; odd++) begin
            logic [15:0] bar;
            bar = 16'h3C40 | 16'(odd);
            wr(8'h04, 2'b11, bar);
            for (int kind = 0; kind < 4; kind++)
              for (int word = 0; word < 2; word++)
                for (int am = 0; am < 2; am++)
                  for (int dv = 0; dv < 3; dv++) begin
                    logic [15:0] a, d;
                    bit e;
                    a = (am == 0) ? bar : (bar ^ 16'h0100);
                    d = (dv == 0) ? bdr_val : (dv == 1) ? (bdr_val ^ 16'h0100) : (bdr_val ^ 16'h0001);
                    e = exp_hit(sel, qual, dce, kind, word[0], a, d, bar, bdr_val);
                    wr(8'h02, 2'b01, 16'h0002);
                    cyc(kind, word[0], a, d);
                    chk("R3 R5 R6 R7 sweep irq", {15'd0, brk_irq}, {15'd0, e});
                    rd(8'h02, v);
                    chk("R3 R5 R6 R7 sweep flag", v, 16'h0002 | {15'd0, e});
                  end
          end
        end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule